// File: doc/BRIEF.md
# Register Target for a Two-Wire Serial Bus with Alert Response

This block is a target on a two-wire serial bus. It gives a host access to a byte-wide register file at a fixed 7-bit bus address, 1100100. After the address, the host writes a command byte that loads an internal pointer. In a write, every data byte that follows is stored at the pointer, and the pointer then moves on by one. In a read, the host writes the pointer, sends a repeated START with the read bit set, and then receives bytes. Each byte the host acknowledges moves the pointer on and fetches the next register.

The block also shares an interrupt line with other targets. An alert-pending input arms it to answer the alert response address, 0001100 with the read bit set. When armed, it returns its own address followed by a 1. While it sends, it compares every 1 it releases against the line. If another target pulls the line low, this block gives way, so the lowest address wins. A complete, uncontested answer produces a one-cycle clear strobe. After that, the block ignores further alert response requests until the alert input falls and rises again.

The register file is read as 16-bit pairs. The even byte is the high byte. When the high byte of a pair is fetched, the low byte is saved. If the next fetch in the same transfer is that low byte, the saved copy is sent, so a register that changes between the two bytes cannot give a torn value. SCL and SDA arrive as raw pins sampled by the core clock. The block controls SDA only through a pull-down output.

Top module: `alert_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only if its upper seven bits equal 1100100, or if it is the alert response case in R6. For any other address byte, the pull-down stays released during the acknowledge clock, and the block ignores the bus until the next START.
- R2: In a write (address bit 0 = 0), the first byte after the address loads the pointer. Each later byte is acknowledged and gives one `reg_wr_o` pulse carrying the pointer and the byte. The pointer is one higher on the following cycle.
- R3: In a read (address bit 0 = 1), bytes are sent MSB first, starting at the pointer. A master ACK (SDA low in the ninth clock) advances the pointer and sends the next register. A master NACK ends the transfer.
- R4: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A repeated START restarts address reception just like a START, and a STOP releases SDA.
- R5: The pull-down output becomes active only while SCL is low. The target's acknowledge occupies the ninth clock of a byte.
- R6: The alert response address 0001100 with the read bit set (byte 0x19) is acknowledged only while `alert_i` is high and armed. Otherwise it is not acknowledged.
- R7: The answer to the alert response is the byte 0x C9 (own address then a 1), sent MSB first. If the answer completes uncontested, `alert_clr_o` pulses for exactly one cycle.
- R8: If the block releases SDA to send a 1 but samples SDA low on the SCL rising edge, it stops driving for the rest of the byte and does not pulse `alert_clr_o`. It stays armed, so it answers the next alert response.
- R9: After an uncontested alert answer, alert response requests are not acknowledged until `alert_i` has gone low and high again.
- R10: If a read fetches an even byte and then the following odd byte in the same transfer, the odd byte sent is its value at the moment the even byte was fetched.
- R11: After reset, the pull-down is released and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level (wired-AND line) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | AW (8) | Register pointer, used for writes and for pair reads |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data byte |
| reg_pair_rdata_i | input | 16 | Register pair holding `reg_addr_o`: [15:8] even byte, [7:0] odd byte |
| alert_i | input | 1 | Alert pending level |
| alert_clr_o | output | 1 | One-cycle pulse after an uncontested alert answer |

## Verification
The assertions assume SCL stays at each level for several core clocks. They also assume SDA is changed by masters only while SCL is low, except to form START and STOP. The bench's bus tasks hold each SCL phase for eight clocks and move SDA four clocks into the low phase, so the two-flop synchronizer always sees a settled line before an edge. The register pair input is combinational on the pointer, and the bench model drives it that way. In the arbitration case, a second simulated target pulls the line only inside the low phase, the same as a well-behaved master.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_WDATA, S_ACK, S_TX, S_MACK
    } tgt_state_e;

    localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic scl_m; logic scl_s; logic scl_p;
        logic sda_m; logic sda_s; logic sda_p;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d.scl_m = scl_i;
        s_d.scl_s = s_q.scl_m;
        s_d.scl_p = s_q.scl_s;
        s_d.sda_m = sda_i;
        s_d.sda_s = s_q.sda_m;
        s_d.sda_p = s_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_s;
    assign sda_s     = s_q.sda_s;
    assign scl_rise  = s_q.scl_s & ~s_q.scl_p;
    assign scl_fall  = ~s_q.scl_s & s_q.scl_p;
    assign bus_start = s_q.scl_s & s_q.scl_p & s_q.sda_p & ~s_q.sda_s;
    assign bus_stop  = s_q.scl_s & s_q.scl_p & ~s_q.sda_p & s_q.sda_s;
endmodule

// File: rtl/pair_snapshot.sv
module pair_snapshot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        odd_sel,
    input  logic [15:0] pair_i,
    input  logic        fetch,
    input  logic        flush,
    output logic [7:0]  byte_o
);
    typedef struct packed { logic vld; logic [7:0] low; } snap_t;
    snap_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d.vld = 1'b0;
        end else if (fetch) begin
            p_d.vld = ~odd_sel;
            if (!odd_sel) p_d.low = pair_i[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign byte_o = !odd_sel ? pair_i[15:8] : (p_q.vld ? p_q.low : pair_i[7:0]);

    assert_snap_used_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.vld && odd_sel) |-> (byte_o == p_q.low));
endmodule

// File: rtl/alert_arm.sv
module alert_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_i,
    input  logic served,
    output logic armed
);
    logic served_d, served_q;

    always_comb begin
        served_d = served_q;
        if (!alert_i)    served_d = 1'b0;
        else if (served) served_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) served_q <= 1'b0;
        else        served_q <= served_d;
    end

    assign armed = alert_i & ~served_q;

    assert_served_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(served) |-> !armed);
endmodule

// File: rtl/alert_i2c_target.sv
module alert_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter logic [6:0]  DEV_ADDR = 7'b1100100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_wr_o,
    output logic [7:0]    reg_wdata_o,
    input  logic [15:0]   reg_pair_rdata_i,
    input  logic          alert_i,
    output logic          alert_clr_o
);
    localparam logic [7:0] ALERT_REPLY = {DEV_ADDR, 1'b1};

    typedef struct packed {
        tgt_state_e    state;
        tgt_state_e    after;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic          pull;
        logic          ara;
        logic          mack;
        logic [AW-1:0] ptr;
        logic          wr;
        logic [7:0]    wdata;
        logic          clr;
    } tgt_regs_t;

    tgt_regs_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic armed, fetch;
    logic [7:0] rd_byte;

    i2c_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    pair_snapshot u_snap (
        .clk(clk), .rst_n(rst_n), .odd_sel(r_q.ptr[0]), .pair_i(reg_pair_rdata_i),
        .fetch(fetch), .flush(bus_start | bus_stop), .byte_o(rd_byte)
    );

    alert_arm u_arm (
        .clk(clk), .rst_n(rst_n), .alert_i(alert_i), .served(r_q.clr), .armed(armed)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr    = 1'b0;
        r_d.clr   = 1'b0;
        fetch     = 1'b0;
        if (r_q.wr) r_d.ptr = r_q.ptr + AW'(1);

        if (bus_start) begin
            r_d.state = S_ADDR;
            r_d.cnt   = '0;
            r_d.pull  = 1'b0;
            r_d.ara   = 1'b0;
        end else if (bus_stop) begin
            r_d.state = S_IDLE;
            r_d.pull  = 1'b0;
        end else begin
            case (r_q.state)
                S_ADDR, S_CMD, S_WDATA: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt   = '0;
                        r_d.pull  = 1'b1;
                        r_d.state = S_ACK;
                        if (r_q.state == S_ADDR) begin
                            if (r_q.sh[7:1] == DEV_ADDR) begin
                                r_d.after = r_q.sh[0] ? S_TX : S_CMD;
                            end else if (r_q.sh == {ALERT_RESP_ADDR, 1'b1} && armed) begin
                                r_d.after = S_TX;
                                r_d.ara   = 1'b1;
                            end else begin
                                r_d.pull  = 1'b0;
                                r_d.state = S_IDLE;
                            end
                        end else if (r_q.state == S_CMD) begin
                            r_d.ptr   = r_q.sh[AW-1:0];
                            r_d.after = S_WDATA;
                        end else begin
                            r_d.wr    = 1'b1;
                            r_d.wdata = r_q.sh;
                            r_d.after = S_WDATA;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        r_d.state = r_q.after;
                        r_d.cnt   = '0;
                        if (r_q.after == S_TX) begin
                            r_d.tx   = r_q.ara ? ALERT_REPLY : rd_byte;
                            fetch    = ~r_q.ara;
                            r_d.pull = r_q.ara ? ~ALERT_REPLY[7] : ~rd_byte[7];
                        end else begin
                            r_d.pull = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 4'd1;
                        if (r_q.ara && !r_q.pull && !sda_s) begin
                            r_d.state = S_IDLE;
                            r_d.pull  = 1'b0;
                        end else if (r_q.ara && r_q.cnt == 4'd7) begin
                            r_d.clr = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.pull  = 1'b0;
                            r_d.state = S_MACK;
                        end else begin
                            r_d.pull = ~r_q.tx[3'd7 - r_q.cnt[2:0]];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                        if (!sda_s && !r_q.ara) r_d.ptr = r_q.ptr + AW'(1);
                    end else if (scl_fall) begin
                        if (r_q.mack && !r_q.ara) begin
                            r_d.state = S_TX;
                            r_d.cnt   = '0;
                            r_d.tx    = rd_byte;
                            fetch     = 1'b1;
                            r_d.pull  = ~rd_byte[7];
                        end else begin
                            r_d.state = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_pull_o  = r_q.pull;
    assign reg_addr_o  = r_q.ptr;
    assign reg_wr_o    = r_q.wr;
    assign reg_wdata_o = r_q.wdata;
    assign alert_clr_o = r_q.clr;

    assert_pull_low_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);
    assert_write_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> (reg_addr_o == AW'($past(reg_addr_o) + AW'(1))));
    assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr_o |=> !alert_clr_o);
    assert_ara_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.state == S_ACK) && r_q.ara) |-> $past(armed));
endmodule

// File: tb/sim_alert_i2c_target.sv
module sim_alert_i2c_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, other_pull = 1'b0, alert = 1'b0;
    logic pull, wr, clr;
    logic [7:0] addr, wdata;
    logic [15:0] pair;
    wire sda_line = sda_m & ~pull & ~other_pull;

    logic [7:0] mem [256];
    assign pair = {mem[{addr[7:1], 1'b0}], mem[{addr[7:1], 1'b1}]};

    alert_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(pull), .reg_addr_o(addr), .reg_wr_o(wr), .reg_wdata_o(wdata),
        .reg_pair_rdata_i(pair), .alert_i(alert), .alert_clr_o(clr)
    );

    int tests = 0, fails = 0;
    int clr_cnt = 0, r5_viol = 0, wr_bad = 0;
    logic [15:0] expq [$];
    logic prev_pull = 1'b0;
    bit done = 1'b0;

    // reference model: register file, expected write list, bus rule monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pull && !prev_pull && scl_m) r5_viol++;
            if (clr) clr_cnt++;
            if (wr) begin
                if (expq.size() == 0) wr_bad++;
                else begin
                    if (expq[0] != {addr, wdata}) wr_bad++;
                    void'(expq.pop_front());
                end
                mem[addr] = wdata;
            end
        end
        prev_pull = pull;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; other_pull = 1'b0; wt(4);
        scl_m = 1'b1; wt(8);
        sda_m = 1'b0; wt(8);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; other_pull = 1'b0; wt(4);
        scl_m = 1'b1; wt(8);
        sda_m = 1'b1; wt(8);
    endtask

    task automatic bit_xfer(input bit b, input bit o, output bit s);
        sda_m = b; other_pull = o; wt(4);
        scl_m = 1'b1; wt(4);
        s = sda_line; wt(4);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], 1'b0, s);
        bit_xfer(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic [7:0] ob, input bit mack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, ~ob[i], s);
            d[i] = s;
        end
        bit_xfer(~mack, 1'b0, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        int c0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        wt(5);
        rst_n = 1'b1;
        wt(5);
        check(pull == 1'b0, "R11 pull after reset", pull, 0);
        check(addr == 8'h00, "R11 pointer after reset", addr, 0);

        // R2 write burst
        expq.push_back({8'h04, 8'h5A});
        expq.push_back({8'h05, 8'hA5});
        bus_start();
        wr_byte(8'hC8, ack); check(ack, "R1 own write address ack", ack, 1);
        wr_byte(8'h04, ack); check(ack, "R2 command ack", ack, 1);
        wr_byte(8'h5A, ack); check(ack, "R2 data ack", ack, 1);
        wr_byte(8'hA5, ack);
        bus_stop();
        wt(4);
        check(addr == 8'h06, "R2 pointer advanced", addr, 8'h06);
        check(expq.size() == 0 && wr_bad == 0, "R2 writes seen", wr_bad, 0);
        check(pull == 1'b0, "R4 released after stop", pull, 0);

        // R3 read with repeated start
        bus_start();
        wr_byte(8'hC8, ack);
        wr_byte(8'h04, ack);
        bus_start();
        wr_byte(8'hC9, ack); check(ack, "R4 repeated start read address ack", ack, 1);
        rd_byte(8'hFF, 1'b1, d); check(d == 8'h5A, "R3 first read byte", d, 8'h5A);
        rd_byte(8'hFF, 1'b0, d); check(d == 8'hA5, "R3 second read byte", d, 8'hA5);
        bus_stop();

        // R1 foreign address ignored
        bus_start();
        wr_byte(8'hA0, ack); check(!ack, "R1 foreign address nack", ack, 0);
        wr_byte(8'h07, ack); check(!ack, "R1 ignored after nack", ack, 0);
        bus_stop();
        wt(4);
        check(wr_bad == 0, "R1 no write for foreign address", wr_bad, 0);

        // R6 alert response while no alert
        bus_start();
        wr_byte(8'h19, ack); check(!ack, "R6 no ack without alert", ack, 0);
        bus_stop();

        // R7 uncontested answer
        alert = 1'b1; wt(4);
        c0 = clr_cnt;
        bus_start();
        wr_byte(8'h19, ack); check(ack, "R6 ack with alert", ack, 1);
        rd_byte(8'hFF, 1'b0, d); check(d == 8'hC9, "R7 answer byte", d, 8'hC9);
        bus_stop();
        check(clr_cnt == c0 + 1, "R7 one clear pulse", clr_cnt - c0, 1);

        // R9 no re-answer until new alert
        bus_start();
        wr_byte(8'h19, ack); check(!ack, "R9 ignored after success", ack, 0);
        bus_stop();
        alert = 1'b0; wt(4); alert = 1'b1; wt(4);

        // R8 arbitration loss against lower address 0010000
        c0 = clr_cnt;
        bus_start();
        wr_byte(8'h19, ack); check(ack, "R9 new alert acknowledged", ack, 1);
        rd_byte(8'h21, 1'b0, d); check(d == 8'h21, "R8 lower address wins", d, 8'h21);
        bus_stop();
        check(clr_cnt == c0, "R8 no clear on loss", clr_cnt - c0, 0);
        bus_start();
        wr_byte(8'h19, ack); check(ack, "R8 still armed after loss", ack, 1);
        rd_byte(8'hFF, 1'b0, d); check(d == 8'hC9, "R8 retry answer", d, 8'hC9);
        bus_stop();
        check(clr_cnt == c0 + 1, "R8 clear after retry", clr_cnt - c0, 1);
        alert = 1'b0;

        // R10 pair snapshot
        expq.push_back({8'h08, 8'h12});
        expq.push_back({8'h09, 8'h34});
        bus_start();
        wr_byte(8'hC8, ack); wr_byte(8'h08, ack); wr_byte(8'h12, ack); wr_byte(8'h34, ack);
        bus_stop();
        bus_start();
        wr_byte(8'hC8, ack); wr_byte(8'h08, ack);
        bus_start();
        wr_byte(8'hC9, ack);
        mem[9] = 8'h99;
        rd_byte(8'hFF, 1'b1, d); check(d == 8'h12, "R10 high byte", d, 8'h12);
        rd_byte(8'hFF, 1'b0, d); check(d == 8'h34, "R10 low byte from snapshot", d, 8'h34);
        bus_stop();
        bus_start();
        wr_byte(8'hC8, ack); wr_byte(8'h09, ack);
        bus_start();
        wr_byte(8'hC9, ack);
        rd_byte(8'hFF, 1'b0, d); check(d == 8'h99, "R10 fresh low byte", d, 8'h99);
        bus_stop();

        wt(10);
        check(r5_viol == 0, "R5 pull rises only with SCL low", r5_viol, 0);
        check(wr_bad == 0 && expq.size() == 0, "R2 write model", wr_bad, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule